// File: doc/BRIEF.md
# ADC Interrupt Flag Aggregator

This block holds the 32-bit status and interrupt flag word of a twelve-channel sampling converter that runs two conversion sequences, A and B. The comparators, the conversion engine and the result registers live elsewhere. Their status reaches this block as plain input signals: per-channel limit events and their enables, per-channel overrun status, the global overrun, data-valid and end-of-sequence pulses of each sequence, each sequence's mode bit, and a strobe that marks a read of each sequence's global data register.

Software sees one register through a flat read/write port with no address. Reads have no side effects. A write clears flags wherever the written word holds a 1. Four request outputs drive the interrupt controller or the DMA engine. They are the two sequence flags, the threshold summary and the overrun summary, each gated by its own enable input.

Each sequence flag behaves in one of two ways, chosen by its mode bit. With mode 0 it reports per-conversion data and drops when the global data register is read. With mode 1 it reports a finished sequence and stays set until software writes a 1 to it.

Top module: `adc_irq_flags`

## Requirements
- R1: After reset, with every status input low, the read word is 0 and all four request outputs are 0.
- R2: Threshold flag c (bit c, c = 0..11) is set one cycle after an out-of-range event on channel c while that channel's out-of-range enable is high, or after a crossing event while its crossing enable is high. An event whose enable is low leaves the flag clear.
- R3: A write with bit c = 1 clears threshold flag c on the next edge. A write with bit c = 0 leaves it unchanged.
- R4: When an enabled threshold event and a write-one clear of the same bit occur in the same cycle, the flag is 1 afterwards.
- R5: Bits 12..23 show the overrun inputs of channels 0..11, and bits 24 and 25 show the global overrun inputs of sequence A and B, in the same cycle with no register stage.
- R6: With mode 0, the sequence flag (bit 28 for A, bit 29 for B) sets one cycle after a data-valid pulse and clears one cycle after a global-data read strobe. If both occur in the same cycle, the flag stays set. In this mode, write-one and end-of-sequence pulses have no effect on it.
- R7: With mode 1, the sequence flag sets one cycle after an end-of-sequence pulse and clears one cycle after a write with its bit = 1. In this mode, data-valid pulses and read strobes have no effect on it.
- R8: With mode 1, an end-of-sequence pulse and a write-one clear of the same flag in the same cycle leave the flag set.
- R9: Bit 30 is the OR of the twelve threshold flags. It falls only when all of them are clear.
- R10: Bit 31 is the OR of all channel overrun inputs, together with the global overrun of each sequence whose mode bit is 0.
- R11: Bits 26 and 27 always read 0. Writes to bits 12..27, 30 and 31 change nothing.
- R12: Request output bit 0 is flag A and bit 1 is flag B. Bit 2 is the threshold summary (bit 30) and bit 3 is the overrun summary (bit 31). Each output is its source ANDed with the enable input of the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lim_oor_evt_i | input | 12 | Out-of-range event pulse, one per channel |
| lim_cross_evt_i | input | 12 | Threshold-crossing event pulse, one per channel |
| lim_oor_en_i | input | 12 | Enables the out-of-range event, one per channel |
| lim_cross_en_i | input | 12 | Enables the crossing event, one per channel |
| ch_ovr_i | input | 12 | Overrun status of each channel result |
| seq_ovr_i | input | 2 | Global overrun of sequence A (bit 0) and sequence B (bit 1) |
| seq_dvalid_i | input | 2 | Pulse at the end of each conversion of a sequence |
| seq_done_i | input | 2 | Pulse at the end of a whole sequence |
| seq_mode_i | input | 2 | Sequence flag mode: 0 per conversion, 1 per sequence |
| gdat_rd_i | input | 2 | Strobe that marks a read of a sequence's global data register |
| irq_en_i | input | 4 | Enable for each request output |
| wr_en_i | input | 1 | Write strobe of the register port |
| wdata_i | input | 32 | Write data; a 1 clears the matching clearable flag |
| rdata_o | output | 32 | Current register value |
| irq_o | output | 4 | Request outputs: A, B, threshold, overrun |

## Verification
The assertions assume that event, done, data-valid and read-strobe inputs are pulses that are stable between clock edges. They also assume that the mode bits do not change while a sequence pulse is in flight, since the flag reads the mode in the same cycle. The stimulus drives every input one time unit after a rising edge and holds each pulse for exactly one cycle. It changes the mode bits only while the sequence inputs are idle. It checks registered results after the next edge and combinational mirrors before any further edge.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
   // index of each request output
   localparam int IRQ_SEQ_A = 0;
   localparam int IRQ_SEQ_B = 1;
   localparam int IRQ_LIMIT = 2;
   localparam int IRQ_OVRUN = 3;
   localparam int IRQ_COUNT = 4;

   typedef enum logic {
      SEQ_PER_CONV  = 1'b0,
      SEQ_PER_BURST = 1'b1
   } seq_mode_e;
endpackage

// File: rtl/adc_irq_limit_bank.sv
module adc_irq_limit_bank #(
   parameter int NUM_CH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] oor_evt_i,
   input  logic [NUM_CH-1:0] cross_evt_i,
   input  logic [NUM_CH-1:0] oor_en_i,
   input  logic [NUM_CH-1:0] cross_en_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] flags_o,
   output logic              any_o
);
   logic [NUM_CH-1:0] hit;
   logic [NUM_CH-1:0] flag_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign hit[c] = (oor_evt_i[c] & oor_en_i[c]) | (cross_evt_i[c] & cross_en_i[c]);

      // a new event outranks a clear in the same cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q[c] <= 1'b0;
         else if (hit[c])   flag_q[c] <= 1'b1;
         else if (clr_i[c]) flag_q[c] <= 1'b0;
      end
   end

   assign flags_o = flag_q;
   assign any_o   = |flag_q;

   // R2 / R4: every enabled event leaves its flag set
   p_lim_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(hit)) == $past(hit)));

   // R3: flags neither hit nor cleared keep their value
   p_lim_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((flag_q ^ $past(flag_q)) & ~$past(hit | clr_i)) == '0));

   // R3: a clear without an event leaves the flag low
   p_lim_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(clr_i & ~hit)) == '0));
endmodule

// File: rtl/adc_irq_seq_flag.sv
module adc_irq_seq_flag
   import adc_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic dvalid_i,
   input  logic done_i,
   input  logic rd_i,
   input  logic wr_clr_i,
   output logic flag_o
);
   logic      flag_q;
   logic      set_now;
   logic      clr_now;
   seq_mode_e mode;

   assign mode = seq_mode_e'(mode_i);

   always_comb begin
      unique case (mode)
         SEQ_PER_BURST: begin
            set_now = done_i;
            clr_now = wr_clr_i;
         end
         default: begin
            set_now = dvalid_i;
            clr_now = rd_i;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_now) flag_q <= 1'b1;
      else if (clr_now) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R6: per-conversion mode, a read without new data drops the flag
   p_conv_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i && rd_i && !dvalid_i) |=> !flag_o);

   // R6: per-conversion mode, new data always raises the flag
   p_conv_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i && dvalid_i) |=> flag_o);

   // R7 / R8: per-sequence mode, a finished sequence raises the flag
   p_burst_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && done_i) |=> flag_o);

   // R7: per-sequence mode, data-valid and read strobes change nothing
   p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && !done_i && !wr_clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/adc_irq_flags.sv
module adc_irq_flags
   import adc_irq_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_CH  = 12,
   parameter int NUM_SEQ = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    lim_oor_evt_i,
   input  logic [NUM_CH-1:0]    lim_cross_evt_i,
   input  logic [NUM_CH-1:0]    lim_oor_en_i,
   input  logic [NUM_CH-1:0]    lim_cross_en_i,
   input  logic [NUM_CH-1:0]    ch_ovr_i,
   input  logic [NUM_SEQ-1:0]   seq_ovr_i,
   input  logic [NUM_SEQ-1:0]   seq_dvalid_i,
   input  logic [NUM_SEQ-1:0]   seq_done_i,
   input  logic [NUM_SEQ-1:0]   seq_mode_i,
   input  logic [NUM_SEQ-1:0]   gdat_rd_i,
   input  logic [IRQ_COUNT-1:0] irq_en_i,
   input  logic                 wr_en_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic [IRQ_COUNT-1:0] irq_o
);
   // field layout, low fields packed upward, summaries packed downward
   localparam int OVR_LSB  = NUM_CH;
   localparam int SOVR_LSB = 2 * NUM_CH;
   localparam int SINT_LSB = DATA_W - 4;
   localparam int LIM_BIT  = DATA_W - 2;
   localparam int OVR_BIT  = DATA_W - 1;

   if (NUM_SEQ != 2) begin : g_bad_seq
      $error("adc_irq_flags: the layout holds exactly two sequences");
   end
   if (SOVR_LSB + NUM_SEQ > SINT_LSB) begin : g_bad_width
      $error("adc_irq_flags: DATA_W too small for NUM_CH");
   end

   logic [NUM_CH-1:0]    lim_flags;
   logic                 lim_any;
   logic [NUM_SEQ-1:0]   seq_flag;
   logic [NUM_SEQ-1:0]   seq_ovr_live;
   logic                 ovr_any;
   logic [IRQ_COUNT-1:0] irq_src;
   logic                 unused_wr_bits;

   assign unused_wr_bits = ^{wdata_i[DATA_W-1:SINT_LSB+NUM_SEQ], wdata_i[SINT_LSB-1:NUM_CH]};

   adc_irq_limit_bank #(.NUM_CH(NUM_CH)) u_limit (
      .clk         (clk),
      .rst_n       (rst_n),
      .oor_evt_i   (lim_oor_evt_i),
      .cross_evt_i (lim_cross_evt_i),
      .oor_en_i    (lim_oor_en_i),
      .cross_en_i  (lim_cross_en_i),
      .clr_i       (wdata_i[NUM_CH-1:0] & {NUM_CH{wr_en_i}}),
      .flags_o     (lim_flags),
      .any_o       (lim_any)
   );

   for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
      adc_irq_seq_flag u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode_i   (seq_mode_i[s]),
         .dvalid_i (seq_dvalid_i[s]),
         .done_i   (seq_done_i[s]),
         .rd_i     (gdat_rd_i[s]),
         .wr_clr_i (wr_en_i & wdata_i[SINT_LSB+s]),
         .flag_o   (seq_flag[s])
      );
      // a sequence's global overrun counts only in per-conversion mode
      assign seq_ovr_live[s] = seq_ovr_i[s] & ~seq_mode_i[s];
   end

   assign ovr_any = (|ch_ovr_i) | (|seq_ovr_live);

   always_comb begin
      rdata_o                          = '0;
      rdata_o[NUM_CH-1:0]              = lim_flags;
      rdata_o[OVR_LSB +: NUM_CH]       = ch_ovr_i;
      rdata_o[SOVR_LSB +: NUM_SEQ]     = seq_ovr_i;
      rdata_o[SINT_LSB +: NUM_SEQ]     = seq_flag;
      rdata_o[LIM_BIT]                 = lim_any;
      rdata_o[OVR_BIT]                 = ovr_any;
   end

   always_comb begin
      irq_src            = '0;
      irq_src[IRQ_SEQ_A] = seq_flag[0];
      irq_src[IRQ_SEQ_B] = seq_flag[1];
      irq_src[IRQ_LIMIT] = lim_any;
      irq_src[IRQ_OVRUN] = ovr_any;
   end

   if (IRQ_REG) begin : g_irq_reg
      logic [IRQ_COUNT-1:0] irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= '0;
         else        irq_q <= irq_src & irq_en_i;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_src & irq_en_i;

      // R12: no request leaves while its enable is low
      p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
         ((irq_o & ~irq_en_i) == '0));
   end

   // R11: the gap bits never read as one
   p_gap_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o[SINT_LSB-1:SOVR_LSB+NUM_SEQ] == '0));

   // R10: any channel overrun shows in the overrun summary
   p_ovr_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_ovr_i) |-> rdata_o[OVR_BIT]);

   // R9: the threshold summary is low only with every flag low
   p_lim_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_o[LIM_BIT] |-> (rdata_o[NUM_CH-1:0] == '0));
endmodule

// File: tb/adc_irq_flags_bench.sv
module adc_irq_flags_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] lim_oor_evt = '0, lim_cross_evt = '0, lim_oor_en = '0, lim_cross_en = '0;
   logic [11:0] ch_ovr = '0;
   logic [1:0]  seq_ovr = '0, seq_dvalid = '0, seq_done = '0, seq_mode = '0, gdat_rd = '0;
   logic [3:0]  irq_en = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   adc_irq_flags u_adc_irq_flags (
      .clk(clk), .rst_n(rst_n),
      .lim_oor_evt_i(lim_oor_evt), .lim_cross_evt_i(lim_cross_evt),
      .lim_oor_en_i(lim_oor_en), .lim_cross_en_i(lim_cross_en),
      .ch_ovr_i(ch_ovr), .seq_ovr_i(seq_ovr), .seq_dvalid_i(seq_dvalid),
      .seq_done_i(seq_done), .seq_mode_i(seq_mode), .gdat_rd_i(gdat_rd),
      .irq_en_i(irq_en), .wr_en_i(wr_en), .wdata_i(wdata),
      .rdata_o(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic write_word(input logic [31:0] v);
      wr_en = 1'b1;
      wdata = v;
      tick();
      wr_en = 1'b0;
      wdata = '0;
   endtask

   task automatic t_reset();
      chk("R1 read word after reset", rdata, 32'h0);
      chk("R1 requests after reset", {28'h0, irq}, 32'h0);
   endtask

   task automatic t_limit_set();
      lim_oor_en[3] = 1'b1;
      lim_oor_evt[3] = 1'b1;
      lim_cross_evt[5] = 1'b1;
      tick();
      lim_oor_evt = '0;
      lim_cross_evt = '0;
      chk("R2 enabled set, disabled ignored", {20'h0, rdata[11:0]}, 32'h008);
      lim_cross_en[5] = 1'b1;
      lim_cross_evt[5] = 1'b1;
      tick();
      lim_cross_evt = '0;
      chk("R2 crossing event sets", {20'h0, rdata[11:0]}, 32'h028);
      chk("R9 summary high", {31'h0, rdata[30]}, 32'h1);
   endtask

   task automatic t_limit_clear();
      write_word(32'h0);
      chk("R3 write zero keeps flags", {20'h0, rdata[11:0]}, 32'h028);
      write_word(32'h8);
      chk("R3 write one clears bit 3", {20'h0, rdata[11:0]}, 32'h020);
      chk("R9 summary stays with one flag", {31'h0, rdata[30]}, 32'h1);
      write_word(32'h20);
      chk("R3 write one clears bit 5", {20'h0, rdata[11:0]}, 32'h000);
      chk("R9 summary falls", {31'h0, rdata[30]}, 32'h0);
   endtask

   task automatic t_limit_race();
      lim_oor_en[0] = 1'b1;
      lim_oor_evt[0] = 1'b1;
      wr_en = 1'b1;
      wdata = 32'h1;
      tick();
      lim_oor_evt = '0;
      wr_en = 1'b0;
      wdata = '0;
      chk("R4 event beats clear", {20'h0, rdata[11:0]}, 32'h001);
      write_word(32'h1);
      chk("R4 later clear works", {20'h0, rdata[11:0]}, 32'h000);
   endtask

   task automatic t_mirror();
      ch_ovr = 12'hA5C;
      seq_ovr = 2'b10;
      #1;
      chk("R5 overrun mirrors", {18'h0, rdata[25:12]}, {18'h0, 2'b10, 12'hA5C});
      chk("R10 channel overrun summary", {31'h0, rdata[31]}, 32'h1);
      ch_ovr = '0;
      seq_ovr = 2'b01;
      #1;
      chk("R10 sequence overrun in mode 0", {31'h0, rdata[31]}, 32'h1);
      seq_mode = 2'b01;
      #1;
      chk("R10 sequence overrun masked in mode 1", {31'h0, rdata[31]}, 32'h0);
      chk("R5 sequence overrun still shown", {30'h0, rdata[25:24]}, 32'h1);
      seq_ovr = '0;
      seq_mode = '0;
      tick();
   endtask

   task automatic t_mode_conv();
      seq_dvalid[0] = 1'b1;
      tick();
      seq_dvalid = '0;
      chk("R6 data valid sets A", {31'h0, rdata[28]}, 32'h1);
      write_word(32'h1000_0000);
      chk("R6 write one ignored in mode 0", {31'h0, rdata[28]}, 32'h1);
      gdat_rd[0] = 1'b1;
      tick();
      gdat_rd = '0;
      chk("R6 read strobe clears A", {31'h0, rdata[28]}, 32'h0);
      seq_done[0] = 1'b1;
      tick();
      seq_done = '0;
      chk("R6 done pulse ignored in mode 0", {31'h0, rdata[28]}, 32'h0);
      seq_dvalid[0] = 1'b1;
      gdat_rd[0] = 1'b1;
      tick();
      seq_dvalid = '0;
      gdat_rd = '0;
      chk("R6 new data beats read", {31'h0, rdata[28]}, 32'h1);
      gdat_rd[0] = 1'b1;
      tick();
      gdat_rd = '0;
      chk("R6 read clears again", {31'h0, rdata[28]}, 32'h0);
   endtask

   task automatic t_mode_burst();
      seq_mode = 2'b10;
      tick();
      seq_dvalid[1] = 1'b1;
      tick();
      seq_dvalid = '0;
      chk("R7 data valid ignored in mode 1", {31'h0, rdata[29]}, 32'h0);
      seq_done[1] = 1'b1;
      tick();
      seq_done = '0;
      chk("R7 done sets B", {31'h0, rdata[29]}, 32'h1);
      gdat_rd[1] = 1'b1;
      tick();
      gdat_rd = '0;
      chk("R7 read strobe ignored in mode 1", {31'h0, rdata[29]}, 32'h1);
      write_word(32'h2000_0000);
      chk("R7 write one clears B", {31'h0, rdata[29]}, 32'h0);
      seq_done[1] = 1'b1;
      wr_en = 1'b1;
      wdata = 32'h2000_0000;
      tick();
      seq_done = '0;
      wr_en = 1'b0;
      wdata = '0;
      chk("R8 done beats clear", {31'h0, rdata[29]}, 32'h1);
      write_word(32'h2000_0000);
      chk("R8 later clear works", {31'h0, rdata[29]}, 32'h0);
      seq_mode = '0;
      tick();
   endtask

   task automatic t_read_only();
      write_word(32'hFFFF_FFFF);
      chk("R11 write to read-only bits changes nothing", rdata, 32'h0);
      ch_ovr = 12'hFFF;
      seq_ovr = 2'b11;
      #1;
      chk("R11 gap bits read zero", {30'h0, rdata[27:26]}, 32'h0);
      ch_ovr = '0;
      seq_ovr = '0;
      tick();
   endtask

   task automatic t_requests();
      lim_oor_evt[7] = 1'b1;
      lim_oor_en[7] = 1'b1;
      seq_dvalid[0] = 1'b1;
      tick();
      lim_oor_evt = '0;
      seq_dvalid = '0;
      ch_ovr[2] = 1'b1;
      #1;
      chk("R12 all enables low", {28'h0, irq}, 32'h0);
      irq_en = 4'hF;
      #1;
      chk("R12 order A,B,threshold,overrun", {28'h0, irq}, 32'hD);
      irq_en = 4'b0100;
      #1;
      chk("R12 threshold only", {28'h0, irq}, 32'h4);
      irq_en = '0;
      ch_ovr = '0;
      tick();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      #1;
      t_reset();
      t_limit_set();
      t_limit_clear();
      t_limit_race();
      t_mirror();
      t_mode_conv();
      t_mode_burst();
      t_read_only();
      t_requests();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule